// File: doc/BRIEF.md
# Three-Mode Interrupt Vector Resolver

This block sits beside a small 8-bit CPU core and works out where the core goes when it accepts a maskable interrupt. It holds a 2-bit mode register and an 8-bit table-pointer register, both written through simple command inputs. When the core signals that it has accepted an interrupt, the block samples the byte the interrupting device drives on the data bus. It then forms the handler address in one of three ways.

The first way decodes a restart opcode into one of eight page-zero call targets. The second ignores the bus and always uses a fixed address of 0x0038. The third is an indirect lookup: the table pointer and the device byte form a 16-bit slot address, and the block reads the two-byte handler address from memory there. Every accepted interrupt ends with a one-cycle request to save the program counter and then a one-cycle jump strobe carrying the target. The only exception is a malformed restart opcode, which raises an error pulse instead.

Top module: `irq_vector_unit`

## Requirements
- R1: After reset the mode is 0, the table pointer is 0x00, and busy, push_req, jump_valid, mem_rd and vec_err are all low.
- R2: A mode write with value 0, 1 or 2 selects that mode from the next cycle on. A mode write with value 3 is ignored and the previous mode stays in force.
- R3: In mode 0, a bus byte matching 11xxx111 is a restart opcode. The cycle after acceptance, push_req is high. In the cycle after that, jump_valid is high and jump_addr = {8'h00, 2'b00, byte[5:3], 3'b000}, which is one of 0x00, 0x08, ..., 0x38.
- R4: In mode 0, a bus byte that does not match 11xxx111 makes vec_err high for exactly the cycle after acceptance. No push_req, jump_valid or mem_rd follows.
- R5: In mode 1, the bus byte is ignored. push_req is high the cycle after acceptance, and jump_valid follows with jump_addr = 0x0038. No error is raised, whatever the byte.
- R6: In mode 2, mem_rd is high in the first two cycles after acceptance. mem_addr is {table pointer, byte} in the first cycle and that value plus 1 (a 16-bit increment) in the second. Read data arrives on mem_rdata one cycle after each read.
- R7: In mode 2, push_req is high in the fourth cycle after acceptance and jump_valid in the fifth. jump_addr is {byte read at the second address, byte read at the first address}.
- R8: Each accepted interrupt that is not rejected produces exactly one push_req cycle, immediately followed by exactly one jump_valid cycle.
- R9: busy is high from the cycle after acceptance up to and including the jump (or error) cycle. An irq_ack while busy is high is ignored.
- R10: The table pointer and the mode can be written at any time. A write in the same cycle as acceptance, or during a fetch, does not change the interrupt in flight; it applies to the next interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Mode-set command strobe |
| mode_val | input | 2 | Requested mode number |
| tptr_wr | input | 1 | Table-pointer write strobe |
| tptr_val | input | 8 | New table-pointer value |
| irq_ack | input | 1 | Core accepts a maskable interrupt this cycle |
| vec_byte | input | 8 | Byte driven on the data bus by the device |
| mem_rd | output | 1 | Table read request |
| mem_addr | output | 16 | Table read address |
| mem_rdata | input | 8 | Read data, one cycle after mem_rd |
| busy | output | 1 | An interrupt is being resolved |
| push_req | output | 1 | Request to save the program counter |
| jump_valid | output | 1 | Jump target is valid |
| jump_addr | output | 16 | Handler address |
| vec_err | output | 1 | Malformed restart opcode in mode 0 |

## Verification
Register writes and interrupt acceptance can land on the same clock edge. The bench provokes this by raising tptr_wr or mode_wr together with irq_ack, and also in the middle of a table fetch. It judges the outcome by the read addresses and jump target of the interrupt in flight, which must reflect the old values, and by the next interrupt, which must reflect the new ones. A second irq_ack while busy is also overlapped with a running sequence, and the event stream must stay unchanged.

// File: rtl/irq_vector_unit.sv
module irq_vector_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_wr,
  input  logic [1:0]  mode_val,
  input  logic        tptr_wr,
  input  logic [7:0]  tptr_val,
  input  logic        irq_ack,
  input  logic [7:0]  vec_byte,
  output logic        mem_rd,
  output logic [15:0] mem_addr,
  input  logic [7:0]  mem_rdata,
  output logic        busy,
  output logic        push_req,
  output logic        jump_valid,
  output logic [15:0] jump_addr,
  output logic        vec_err
);

  localparam logic [15:0] FIXED_TARGET = 16'h0038;

  typedef enum logic [2:0] {
    S_IDLE, S_RDLO, S_RDHI, S_WAIT, S_PUSH, S_JUMP, S_ERR
  } state_t;

  state_t      state;
  logic [1:0]  mode_q;
  logic [7:0]  tptr_q;
  logic [15:0] addr_q;
  logic [7:0]  lo_q;
  logic        rst_ok;

  assign rst_ok = (vec_byte[7:6] == 2'b11) && (vec_byte[2:0] == 3'b111);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      mode_q <= 2'd0;
      tptr_q <= 8'h00;
      addr_q <= 16'h0000;
      lo_q   <= 8'h00;
    end else begin
      if (mode_wr && mode_val != 2'd3) mode_q <= mode_val;
      if (tptr_wr) tptr_q <= tptr_val;
      case (state)
        S_IDLE: if (irq_ack) begin
          case (mode_q)
            2'd0: if (rst_ok) begin
              state  <= S_PUSH;
              addr_q <= {8'h00, 2'b00, vec_byte[5:3], 3'b000};
            end else begin
              state  <= S_ERR;
            end
            2'd1: begin
              state  <= S_PUSH;
              addr_q <= FIXED_TARGET;
            end
            2'd2: begin
              state  <= S_RDLO;
              addr_q <= {tptr_q, vec_byte};
            end
            default: state <= S_IDLE;
          endcase
        end
        S_RDLO: begin
          state  <= S_RDHI;
          addr_q <= addr_q + 16'd1;
        end
        S_RDHI: begin
          state <= S_WAIT;
          lo_q  <= mem_rdata;
        end
        S_WAIT: begin
          state  <= S_PUSH;
          addr_q <= {mem_rdata, lo_q};
        end
        S_PUSH:  state <= S_JUMP;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy       = (state != S_IDLE);
  assign mem_rd     = (state == S_RDLO) || (state == S_RDHI);
  assign mem_addr   = mem_rd ? addr_q : 16'h0000;
  assign push_req   = (state == S_PUSH);
  assign jump_valid = (state == S_JUMP);
  assign jump_addr  = jump_valid ? addr_q : 16'h0000;
  assign vec_err    = (state == S_ERR);

endmodule

// File: rtl/irq_vector_unit_chk.sv
module irq_vector_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mode_wr,
  input logic [1:0]  mode_q,
  input logic        irq_ack,
  input logic        mem_rd,
  input logic [15:0] mem_addr,
  input logic        busy,
  input logic        push_req,
  input logic        jump_valid,
  input logic        vec_err
);

  a_r8_push_then_jump: assert property (@(posedge clk) disable iff (!rst_n)
    push_req |=> jump_valid);

  a_r8_jump_after_push: assert property (@(posedge clk) disable iff (!rst_n)
    jump_valid |-> $past(push_req));

  a_r8_single_push: assert property (@(posedge clk) disable iff (!rst_n)
    push_req |=> !push_req);

  a_r4_err_alone: assert property (@(posedge clk) disable iff (!rst_n)
    vec_err |-> (!push_req && !jump_valid && !mem_rd));

  a_r6_second_read_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && $past(mem_rd)) |-> (mem_addr == $past(mem_addr) + 16'd1));

  a_r2_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q != 2'd3);

  a_r2_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_wr |=> $stable(mode_q));

  a_r9_busy_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !busy) |=> busy);

endmodule

bind irq_vector_unit irq_vector_unit_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_q(mode_q),
  .irq_ack(irq_ack), .mem_rd(mem_rd), .mem_addr(mem_addr), .busy(busy),
  .push_req(push_req), .jump_valid(jump_valid), .vec_err(vec_err)
);

// File: tb/irq_vector_unit_tb_top.sv
module irq_vector_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_wr = 1'b0;
  logic [1:0]  mode_val = 2'd0;
  logic        tptr_wr = 1'b0;
  logic [7:0]  tptr_val = 8'h00;
  logic        irq_ack = 1'b0;
  logic [7:0]  vec_byte = 8'h00;
  logic        mem_rd;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata = 8'h00;
  logic        busy, push_req, jump_valid, vec_err;
  logic [15:0] jump_addr;

  always #10 clk = ~clk;

  irq_vector_unit dut_i (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_val(mode_val),
    .tptr_wr(tptr_wr), .tptr_val(tptr_val), .irq_ack(irq_ack),
    .vec_byte(vec_byte), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .busy(busy), .push_req(push_req),
    .jump_valid(jump_valid), .jump_addr(jump_addr), .vec_err(vec_err)
  );

  localparam int K_ERR = 0, K_PUSH = 1, K_JUMP = 2, K_RD = 3;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit mon_on = 1'b0;
  logic [1:0] m_mode = 2'd0;
  logic [7:0] m_tptr = 8'h00;

  int          exp_cyc[$];
  int          exp_kind[$];
  logic [15:0] exp_addr[$];
  string       exp_tag[$];

  function automatic logic [7:0] mem_fn(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rdata <= mem_rd ? mem_fn(mem_addr) : 8'h00;
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic expect_ev(input int c, input int k, input logic [15:0] a,
                           input string t);
    exp_cyc.push_back(c);
    exp_kind.push_back(k);
    exp_addr.push_back(a);
    exp_tag.push_back(t);
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      int k;
      logic [15:0] a;
      bit seen;
      while (exp_cyc.size() > 0 && exp_cyc[0] < cyc) begin
        check(1'b0, exp_tag[0], "missing event kind", -1, exp_kind[0]);
        void'(exp_cyc.pop_front()); void'(exp_kind.pop_front());
        void'(exp_addr.pop_front()); void'(exp_tag.pop_front());
      end
      seen = 1'b1;
      k = 0;
      a = 16'h0;
      if (vec_err) k = K_ERR;
      else if (push_req) k = K_PUSH;
      else if (jump_valid) begin k = K_JUMP; a = jump_addr; end
      else if (mem_rd) begin k = K_RD; a = mem_addr; end
      else seen = 1'b0;
      if (seen) begin
        if (exp_cyc.size() > 0 && exp_cyc[0] == cyc) begin
          check(k == exp_kind[0], exp_tag[0], "event kind", k, exp_kind[0]);
          if (k == K_JUMP || k == K_RD)
            check(a == exp_addr[0], exp_tag[0], "address", a, exp_addr[0]);
          void'(exp_cyc.pop_front()); void'(exp_kind.pop_front());
          void'(exp_addr.pop_front()); void'(exp_tag.pop_front());
        end else begin
          check(1'b0, "R8", "unexpected event kind", k, -1);
        end
      end
    end
  end

  task automatic set_mode(input logic [1:0] v);
    mode_wr = 1'b1; mode_val = v;
    @(negedge clk);
    mode_wr = 1'b0;
    if (v != 2'd3) m_mode = v;
  endtask

  task automatic set_tptr(input logic [7:0] v);
    tptr_wr = 1'b1; tptr_val = v;
    @(negedge clk);
    tptr_wr = 1'b0;
    m_tptr = v;
  endtask

  task automatic fire(input logic [7:0] b, input string tag,
                      input bit wr_p = 1'b0, input logic [7:0] np = 8'h00,
                      input bit wr_m = 1'b0, input logic [1:0] nm = 2'd0,
                      input bit dbl = 1'b0, input bit mid_p = 1'b0);
    int n;
    logic [15:0] base;
    n = cyc;
    case (m_mode)
      2'd0: if (b[7:6] == 2'b11 && b[2:0] == 3'b111) begin
        expect_ev(n + 1, K_PUSH, 16'h0, tag);
        expect_ev(n + 2, K_JUMP, {8'h00, 2'b00, b[5:3], 3'b000}, tag);
      end else begin
        expect_ev(n + 1, K_ERR, 16'h0, tag);
      end
      2'd1: begin
        expect_ev(n + 1, K_PUSH, 16'h0, tag);
        expect_ev(n + 2, K_JUMP, 16'h0038, tag);
      end
      default: begin
        base = {m_tptr, b};
        expect_ev(n + 1, K_RD, base, tag);
        expect_ev(n + 2, K_RD, base + 16'd1, tag);
        expect_ev(n + 4, K_PUSH, 16'h0, tag);
        expect_ev(n + 5, K_JUMP, {mem_fn(base + 16'd1), mem_fn(base)}, tag);
      end
    endcase
    irq_ack = 1'b1; vec_byte = b;
    tptr_wr = wr_p; tptr_val = np;
    mode_wr = wr_m; mode_val = nm;
    @(negedge clk);
    tptr_wr = 1'b0; mode_wr = 1'b0;
    if (wr_p) m_tptr = np;
    if (wr_m && nm != 2'd3) m_mode = nm;
    irq_ack = dbl; vec_byte = ~b;
    check(busy == 1'b1, "R9", "busy after accept", busy, 1);
    if (mid_p) begin tptr_wr = 1'b1; tptr_val = ~m_tptr; m_tptr = ~m_tptr; end
    @(negedge clk);
    irq_ack = 1'b0; tptr_wr = 1'b0;
    repeat (5) @(negedge clk);
    check(busy == 1'b0, "R9", "busy cleared", busy, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check({busy, push_req, jump_valid, mem_rd, vec_err} == 5'b0, "R1",
          "outputs in reset", {busy, push_req, jump_valid, mem_rd, vec_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({busy, push_req, jump_valid, mem_rd, vec_err} == 5'b0, "R1",
          "outputs after reset", {busy, push_req, jump_valid, mem_rd, vec_err}, 0);
    mon_on = 1'b1;

    fire(8'hFF, "R1");
    fire(8'hC7, "R3");
    fire(8'hDF, "R3");
    fire(8'hEF, "R3");
    fire(8'h00, "R4");
    fire(8'hC6, "R4");
    fire(8'h87, "R4");

    set_mode(2'd1);
    fire(8'h00, "R5");
    fire(8'hA5, "R5");
    set_mode(2'd3);
    fire(8'h13, "R2");

    set_mode(2'd2);
    fire(8'h40, "R1");
    set_tptr(8'h12);
    fire(8'h34, "R6");
    fire(8'hFF, "R6");
    set_tptr(8'hFF);
    fire(8'hFF, "R7");
    fire(8'h80, "R9", 1'b0, 8'h00, 1'b0, 2'd0, 1'b1);

    fire(8'h10, "R10", 1'b1, 8'hAB);
    fire(8'h10, "R10");
    fire(8'h22, "R10", 1'b0, 8'h00, 1'b0, 2'd0, 1'b0, 1'b1);
    fire(8'h22, "R10");
    fire(8'h30, "R10", 1'b0, 8'h00, 1'b1, 2'd1);
    fire(8'h30, "R10");
    set_mode(2'd0);
    fire(8'hF7, "R2");

    repeat (4) @(negedge clk);
    check(exp_cyc.size() == 0, "R8", "leftover expected events", exp_cyc.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule